// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block keeps the event flags of an I2C master controller, holds the mask that decides which of those flags may raise an interrupt, and drives a single interrupt request line. The bus engine and the transmit and receive FIFOs report events as one-cycle pulses on a 16-bit event input. Each pulse sets a sticky flag at the matching position. A level input reports whether the bus is busy.

The host uses a small register port with a 2-bit select, a write strobe, a read strobe and 16-bit data. Through it the host can read the flag word and clear flags by writing ones. It can also read and write the mask. A third register returns a small code that names the most urgent pending enabled event among the five main events. A read strobe on that register clears the event it reports. Software can therefore either scan the flag word or take events one at a time through the code.

Top module: `i2c_evt_irq`

## Requirements
- R1: After reset, every flag reads 0 and the mask reads 0x0000. The interrupt line is low and the vector code reads 0. The bus-busy bit is the only exception: it reads as the `bus_busy_i` input.
- R2: A pulse on `evt_pulse[i]` sets flag i in the next cycle for the sticky positions 0 (arbitration lost), 1 (no-ack), 2 (access ready), 3 (receive ready), 4 (transmit ready), 8 (address zero), 9 (addressed as slave), 10 (transmit underflow), 11 (receive overrun), 13 (receive drain) and 14 (transmit drain). The sticky flags form the mask 0x6F1F. Positions 5, 6, 7 and 15 always read 0.
- R3: Flag bit 12 reads the current value of `bus_busy_i` in the same cycle. Writing to bit 12 and pulsing `evt_pulse[12]` have no effect on it.
- R4: A write to the flag register (select 0) clears every sticky flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: The mask register (select 1) stores the bits of the written word that are in 0x6F1F and reads them back. All other mask bits read 0.
- R6: `irq_o` is high exactly when the AND of the flag word and the mask is nonzero.
- R7: The vector register (select 2) reads a code in the low bits, with the upper bits 0. The code is 0 when none of flags 0 to 4 is both set and enabled. Otherwise the code is one plus the lowest such flag index: 1 arbitration lost, 2 no-ack, 3 access ready, 4 receive ready, 5 transmit ready.
- R8: A read strobe on select 2 clears only the flag named by the code it returns. When that code is 0, the strobe clears nothing.
- R9: When an event pulse arrives in the same cycle as a clear of the same flag, whether the clear comes from a write of 1 or from a vector read, the flag ends up set.
- R10: Select 3 reads 0x0000. Writes to select 2 or 3 change no flag and no mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 16 | One-cycle event pulses, one per flag position |
| bus_busy_i | input | 1 | Bus-busy level from the bus engine |
| reg_sel | input | 2 | Register select: 0 flags, 1 mask, 2 vector, 3 reserved |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (acts only on the vector register) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register, same cycle |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The assertions expect `reg_wr` and `reg_rd` to be clean single-cycle strobes. They also expect `reg_sel` and `reg_wdata` to stay steady for the cycle of the strobe, and event pulses to last one cycle at a time. The stimulus drives every input on the falling clock edge and holds it until the next falling edge, so no strobe overlaps an edge where it is being changed. The bench uses collisions between an event and a clear on purpose, to exercise the rule that the event wins. It also sweeps every combination of the five vectored flags against every combination of their mask bits.

// File: rtl/i2c_evt_pkg.sv
// Package: shared widths, bit masks and register selects for the
// I2C interrupt status unit. Assumes a 16-bit register port.
package i2c_evt_pkg;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned NUM_VEC  = 5;
    localparam int unsigned CODE_W   = $clog2(NUM_VEC + 1);
    localparam int unsigned BUSY_POS = 12;
    localparam logic [REG_W-1:0] STICKY_MASK = 16'h6F1F;
    localparam logic [REG_W-1:0] ENABLE_MASK = 16'h6F1F;

    typedef enum logic [1:0] {
        SEL_FLAGS = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_VEC   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/i2c_evt_flag_bank.sv
// Module: sticky event flags. A bit listed in IMPL sets on its event pulse
// and clears on its clear strobe. When both happen in one cycle, the event
// wins. Bits outside IMPL are constant 0.
// Assumes: evt and clr are synchronous to clk.
module i2c_evt_flag_bank #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_sticky
            // Purpose: hold flag i; set wins over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= evt[i] | (flags[i] & ~clr[i]);
            end

            a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
                evt[i] |=> flags[i]);
            a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !evt[i]) |=> !flags[i]);
            a_r4_hold_if_untouched: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !clr[i]) |=> flags[i]);
        end else begin : g_absent
            logic unused_in;
            assign unused_in = evt[i] ^ clr[i];
            assign flags[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_evt_mask_reg.sv
// Module: interrupt mask register. Only the bits in MASK are storage.
// All other bits read 0.
// Assumes: wr_en is a single-cycle strobe.
module i2c_evt_mask_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_store
            // Purpose: load mask bit i on a write.
            always_ff @(posedge clk) begin
                if (!rst_n)     en[i] <= 1'b0;
                else if (wr_en) en[i] <= wdata[i];
            end

            a_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(en[i]));
        end else begin : g_zero
            logic unused_wd;
            assign unused_wd = wdata[i];
            assign en[i]     = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_evt_vec_enc.sv
// Module: priority encoder for the vectored events. Index 0 has the highest
// priority. The code is index+1, or 0 when nothing is pending. hit is
// the one-hot form of the chosen index.
// Assumes: pending is already masked by the enables.
module i2c_evt_vec_enc #(
    parameter int unsigned NV = 5,
    parameter int unsigned CW = $clog2(NV + 1)
) (
    input  logic [NV-1:0] pending,
    output logic [CW-1:0] code,
    output logic [NV-1:0] hit
);
    // Purpose: scan from highest index down so the lowest pending index wins.
    always_comb begin
        code = '0;
        hit  = '0;
        for (int k = NV - 1; k >= 0; k--) begin
            if (pending[k]) begin
                code = CW'(k + 1);
                hit  = '0;
                hit[k] = 1'b1;
            end
        end
    end

    // Purpose: sanity on encoder outputs.
    always_comb begin
        a_r7_hit_onehot: assert ($onehot0(hit));
        a_r7_code_agrees: assert ((code == '0) == (hit == '0));
    end
endmodule

// File: rtl/i2c_evt_irq.sv
// Module: top of the I2C interrupt status unit. It decodes the register
// port, forms the clear strobes for writes of 1 and for vector reads,
// multiplexes read data and drives the interrupt line.
// Assumes: reg_wr and reg_rd are single-cycle strobes that are steady at the edge.
module i2c_evt_irq
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic             bus_busy_i,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_o
);
    localparam int unsigned PAD_W = REG_W - NUM_VEC;

    logic [REG_W-1:0]   flags;
    logic [REG_W-1:0]   en;
    logic [REG_W-1:0]   clr;
    logic [REG_W-1:0]   flag_word;
    logic [NUM_VEC-1:0] vec_hit;
    logic [CODE_W-1:0]  vec_code;
    logic               wr_flags, wr_mask, rd_vec;

    // Purpose: decode the strobes for each register.
    always_comb begin
        wr_flags = reg_wr && (reg_sel == SEL_FLAGS);
        wr_mask  = reg_wr && (reg_sel == SEL_MASK);
        rd_vec   = reg_rd && (reg_sel == SEL_VEC);
    end

    // Purpose: combine clears from writes of 1 and from a vector read.
    always_comb begin
        clr = wr_flags ? reg_wdata : '0;
        if (rd_vec) clr = clr | {{PAD_W{1'b0}}, vec_hit};
    end

    i2c_evt_flag_bank #(.W(REG_W), .IMPL(STICKY_MASK)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_pulse),
        .clr   (clr),
        .flags (flags)
    );

    i2c_evt_mask_reg #(.W(REG_W), .MASK(ENABLE_MASK)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_mask),
        .wdata (reg_wdata),
        .en    (en)
    );

    i2c_evt_vec_enc #(.NV(NUM_VEC), .CW(CODE_W)) u_vec (
        .pending (flags[NUM_VEC-1:0] & en[NUM_VEC-1:0]),
        .code    (vec_code),
        .hit     (vec_hit)
    );

    // Purpose: merge the live bus-busy level into the visible flag word.
    always_comb begin
        flag_word = flags;
        flag_word[BUSY_POS] = bus_busy_i;
    end

    // Purpose: read-data multiplexer.
    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_FLAGS: reg_rdata = flag_word;
            SEL_MASK:  reg_rdata = en;
            SEL_VEC:   reg_rdata = {{(REG_W-CODE_W){1'b0}}, vec_code};
            default:   reg_rdata = '0;
        endcase
    end

    // Purpose: interrupt line from enabled pending flags.
    assign irq_o = |(flags & en);

    a_r7_code_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> irq_o);
    a_r8_vec_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && ((vec_hit & ~evt_pulse[NUM_VEC-1:0]) != '0))
        |=> ((flags[NUM_VEC-1:0] & $past(vec_hit & ~evt_pulse[NUM_VEC-1:0])) == '0));
    a_r10_no_write_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel[1] && !reg_rd) |=> $stable(en));
endmodule

// File: tb/sim_i2c_evt_irq.sv
module sim_i2c_evt_irq;
    localparam logic [15:0] STICKY = 16'h6F1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_pulse = '0;
    logic        bus_busy_i = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] got;

    always #5 clk = ~clk;

    i2c_evt_irq u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy_i(bus_busy_i),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] e);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic vec_pop(output logic [15:0] d);
        reg_sel = 2'd2; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [15:0] lowest_code(input logic [4:0] p);
        for (int k = 0; k < 5; k++) if (p[k]) return 16'(k + 1);
        return 16'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, got); check("R1 flags", got, 16'h0000);
        rd(2'd1, got); check("R1 mask", got, 16'h0000);
        rd(2'd2, got); check("R1 vector", got, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);

        // R2, R3, R4: each event position alone, then clear by writing ones
        for (int i = 0; i < 16; i++) begin
            pulse(16'(1) << i);
            rd(2'd0, got);
            check($sformatf("R2 set bit %0d", i), got, STICKY & (16'(1) << i));
            wr(2'd0, 16'hFFFF);
            rd(2'd0, got);
            check($sformatf("R4 clear bit %0d", i), got, 16'h0000);
        end

        // R3: bus busy is live and write-immune
        bus_busy_i = 1'b1;
        rd(2'd0, got); check("R3 busy high", got, 16'h1000);
        wr(2'd0, 16'h1000);
        rd(2'd0, got); check("R3 busy after write", got, 16'h1000);
        bus_busy_i = 1'b0;
        rd(2'd0, got); check("R3 busy low", got, 16'h0000);

        // R4: partial clears and zero write
        pulse(16'hFFFF);
        rd(2'd0, got); check("R2 all events", got, STICKY);
        wr(2'd0, 16'h0005);
        rd(2'd0, got); check("R4 partial clear", got, STICKY & ~16'h0005);
        wr(2'd0, 16'h0000);
        rd(2'd0, got); check("R4 zero write", got, STICKY & ~16'h0005);

        // R5: mask storage
        wr(2'd1, 16'hFFFF);
        rd(2'd1, got); check("R5 mask all", got, 16'h6F1F);
        wr(2'd1, 16'hA5A5);
        rd(2'd1, got); check("R5 mask pattern", got, 16'hA5A5 & 16'h6F1F);

        // R10: writes to select 2 and 3 are ignored; select 3 reads zero
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        rd(2'd1, got); check("R10 mask kept", got, 16'hA5A5 & 16'h6F1F);
        rd(2'd0, got); check("R10 flags kept", got, STICKY & ~16'h0005);
        rd(2'd3, got); check("R10 sel3 zero", got, 16'h0000);

        // R6: interrupt line against single mask bits with all flags set
        wr(2'd0, 16'hFFFF);
        pulse(16'hFFFF);
        for (int j = 0; j < 16; j++) begin
            wr(2'd1, 16'(1) << j);
            #1 check($sformatf("R6 irq mask bit %0d", j), {15'd0, irq_o}, {15'd0, STICKY[j]});
        end
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'hFFFF);
        #1 check("R6 irq no flags", {15'd0, irq_o}, 16'h0000);

        // R7, R8: vector over all pending x mask combinations of the low five
        for (int e = 0; e < 32; e++) begin
            for (int p = 0; p < 32; p++) begin
                logic [15:0] expc;
                logic [15:0] left;
                wr(2'd0, 16'hFFFF);
                if (p != 0) pulse(16'(p));
                wr(2'd1, 16'(e));
                expc = lowest_code(5'(p & e));
                vec_pop(got);
                check($sformatf("R7 code p=%0d e=%0d", p, e), got, expc);
                left = 16'(p);
                if (expc != 0) left[expc - 1] = 1'b0;
                rd(2'd0, got);
                check($sformatf("R8 after read p=%0d e=%0d", p, e), got, left);
            end
        end

        // R9: event beats a clear by write
        wr(2'd0, 16'hFFFF);
        evt_pulse = 16'h0008;
        wr(2'd0, 16'h0008);
        evt_pulse = '0;
        rd(2'd0, got); check("R9 event vs write clear", got, 16'h0008);

        // R9: event beats a clear by vector read
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'h001F);
        pulse(16'h0001);
        evt_pulse = 16'h0001;
        vec_pop(got);
        evt_pulse = '0;
        check("R9 vec code", got, 16'h0001);
        rd(2'd0, got); check("R9 event vs vector clear", got, 16'h0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule